// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous slave port that gives a host processor access to a small register file through four lines: a serial clock, an active-low select, a read/write strobe and one shared data line. Every access is a 16-bit frame. Four address bits come first, then twelve data bits, both least significant bit first. The port holds two write-only control registers, a 9-bit drive register and a 12-bit mode register, both visible to the rest of the chip on output ports. An 8-bit status word from the chip can be read back over the serial line.

All four serial inputs are brought into the system clock domain by two-flop synchronizers, and edges are detected there. The shared data line appears at the block edge as a separate input, output and output enable, which the pad ring combines. A write is committed only when the whole frame has arrived. A read is started by a rising edge on the read/write strobe after the address has been clocked in. Selecting the port with the strobe already high shifts out whatever the shift register holds, which gives a read-back of the last frame written.

Top module: `sreg_port`

## Requirements
- R1: A frame is 16 rising serial-clock edges: 4 address bits then 12 data bits, each least significant bit first. Rising edges after the 16th within the same selection are ignored.
- R2: Bits are taken only on rising serial-clock edges while select is low. While select is high the frame bit counter stays at zero and serial-clock activity changes no register.
- R3: With read/write low for the whole frame, the register is updated on the 16th rising edge. Address 0 loads data bits 8..0 into the drive register, and address 1 loads all 12 data bits into the mode register.
- R4: Raising select before the 16th rising edge aborts the frame, and both control registers keep their values.
- R5: In a read, the 4 address bits are clocked in with read/write low. A rising edge on read/write after at least 4 address bits loads the addressed word, zero-extended to 12 bits, into the shift register. Bit 0 appears at once and each rising serial-clock edge presents the next bit. After 12 shifts the line carries 0. Address 2 returns `status_in` as it stands at the load.
- R6: `sdio_oe` is 1 only while the synchronized select is low and the synchronized read/write is high. Otherwise it is 0, and `sdio_out` is 0 then.
- R7: Selecting the port while read/write is already high does not load. It shifts out the 12 data bits of the last completed write frame, least significant first.
- R8: While `rst_n` is low, both control registers and `sdio_oe` are 0.
- R9: A write to any address other than 0 or 1 changes no register. A read of any address other than 2 returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| sck | input | 1 | Serial clock from the host, asynchronous |
| sel_n | input | 1 | Active-low port select, asynchronous |
| rw | input | 1 | Read/write strobe: high enables driving the data line, and its rising edge loads a read |
| sdio_in | input | 1 | Data line as seen by the input buffer |
| sdio_out | output | 1 | Value to drive onto the data line |
| sdio_oe | output | 1 | Output enable for the data line |
| status_in | input | 8 | Status word returned by a read of address 2 |
| drive_reg | output | 9 | Drive register (8-bit current code and a range bit) |
| mode_reg | output | 12 | Mode register |

## Verification
The assertions rely on the serial inputs changing slowly against the system clock. Each level of `sck`, `sel_n`, `rw` and `sdio_in` must persist for several system-clock cycles, so that every edge is seen once after synchronization. A read/write edge and a serial-clock edge must never land in the same synchronized cycle. The bench holds each serial-clock phase for six system cycles and sets data three cycles ahead of the rising edge. It changes select and read/write only while the serial clock is low, with several idle cycles between them, so every sampled edge is unambiguous.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
    localparam int SP_ADDR_W = 4;
    localparam int SP_DATA_W = 12;
    localparam int DRV_W     = 9;
    localparam int MODE_W    = 12;
    localparam int STAT_W    = 8;

    localparam logic [SP_ADDR_W-1:0] ADDR_DRIVE = 4'd0;
    localparam logic [SP_ADDR_W-1:0] ADDR_MODE  = 4'd1;
    localparam logic [SP_ADDR_W-1:0] ADDR_STAT  = 4'd2;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
    parameter int             W       = 4,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[i];
                stab_q <= RST_VAL[i];
            end else begin
                meta_q <= async_i[i];
                stab_q <= meta_q;
            end
        end
        assign sync_o[i] = stab_q;
    end
endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
#(
    parameter int AW = SP_ADDR_W,
    parameter int DW = SP_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sck_s,
    input  logic          sel_n_s,
    input  logic          rw_s,
    input  logic          din_s,
    input  logic [DW-1:0] rd_data,
    output logic          wr_en,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wr_data,
    output logic          dout
);
    localparam int FRAME = AW + DW;
    localparam int CW    = $clog2(FRAME + 1);
    localparam logic [CW-1:0] CNT_ADDR = CW'(AW);
    localparam logic [CW-1:0] CNT_END  = CW'(FRAME);
    localparam logic [CW-1:0] CNT_LAST = CW'(FRAME - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [DW-1:0] dat;
        logic          sck_p;
        logic          rw_p;
    } frame_t;

    frame_t st_d, st_q;
    logic   wr_en_d;
    logic   sck_rise;
    logic   rw_rise;

    always_comb begin
        st_d     = st_q;
        wr_en_d  = 1'b0;
        sck_rise = sck_s & ~st_q.sck_p;
        rw_rise  = rw_s & ~st_q.rw_p;
        st_d.sck_p = sck_s;
        st_d.rw_p  = rw_s;
        if (sel_n_s) begin
            st_d.cnt = '0;
        end else if (rw_rise && (st_q.cnt >= CNT_ADDR)) begin
            st_d.dat = rd_data;
        end else if (sck_rise && (st_q.cnt != CNT_END)) begin
            st_d.cnt = st_q.cnt + 1'b1;
            if (rw_s) begin
                st_d.dat = {1'b0, st_q.dat[DW-1:1]};
            end else if (st_q.cnt < CNT_ADDR) begin
                st_d.addr = {din_s, st_q.addr[AW-1:1]};
            end else begin
                st_d.dat = {din_s, st_q.dat[DW-1:1]};
                wr_en_d  = (st_q.cnt == CNT_LAST);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en   = wr_en_d;
    assign wr_data = st_d.dat;
    assign addr    = st_q.addr;
    assign dout    = st_q.dat[0];

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_END);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cnt != $past(st_q.cnt)) && (st_q.cnt != '0)) |->
        ((st_q.cnt == CW'($past(st_q.cnt) + 1'b1)) && $past(sck_s) && !$past(sel_n_s)));

    // R4
    desel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_s |=> (st_q.cnt == '0));
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
    import sreg_pkg::*;
#(
    parameter int AW  = SP_ADDR_W,
    parameter int DW  = SP_DATA_W,
    parameter int DRW = DRV_W,
    parameter int MDW = MODE_W,
    parameter int STW = STAT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [STW-1:0] status_in,
    output logic [DW-1:0]  rd_data,
    output logic [DRW-1:0] drive_reg,
    output logic [MDW-1:0] mode_reg
);
    typedef struct packed {
        logic [DRW-1:0] drv;
        logic [MDW-1:0] mode;
    } regs_t;

    regs_t rg_d, rg_q;

    always_comb begin
        rg_d = rg_q;
        if (wr_en) begin
            if (addr == ADDR_DRIVE) rg_d.drv  = wr_data[DRW-1:0];
            if (addr == ADDR_MODE)  rg_d.mode = wr_data[MDW-1:0];
        end
        rd_data = '0;
        if (addr == ADDR_STAT) rd_data[STW-1:0] = status_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign drive_reg = rg_q.drv;
    assign mode_reg  = rg_q.mode;

    // R3
    drv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.drv) |-> ($past(wr_en) && ($past(addr) == ADDR_DRIVE)));

    // R3
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rg_q.mode) |-> ($past(wr_en) && ($past(addr) == ADDR_MODE)));

    // R9
    bad_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr != ADDR_DRIVE) && (addr != ADDR_MODE)) |=>
        ($stable(rg_q.drv) && $stable(rg_q.mode)));
endmodule

// File: rtl/sreg_port.sv
module sreg_port
    import sreg_pkg::*;
#(
    parameter int AW  = SP_ADDR_W,
    parameter int DW  = SP_DATA_W,
    parameter int DRW = DRV_W,
    parameter int MDW = MODE_W,
    parameter int STW = STAT_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sck,
    input  logic           sel_n,
    input  logic           rw,
    input  logic           sdio_in,
    output logic           sdio_out,
    output logic           sdio_oe,
    input  logic [STW-1:0] status_in,
    output logic [DRW-1:0] drive_reg,
    output logic [MDW-1:0] mode_reg
);
    localparam int NSYNC = 4;
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b0010;

    logic [NSYNC-1:0] raw_in;
    logic [NSYNC-1:0] syn;
    logic             wr_en;
    logic [AW-1:0]    addr;
    logic [DW-1:0]    wr_data;
    logic [DW-1:0]    rd_data;
    logic             dout;

    assign raw_in = {sdio_in, rw, sel_n, sck};

    sreg_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn)
    );

    sreg_frame #(.AW(AW), .DW(DW)) i_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (syn[0]),
        .sel_n_s (syn[1]),
        .rw_s    (syn[2]),
        .din_s   (syn[3]),
        .rd_data (rd_data),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .dout    (dout)
    );

    sreg_regs #(.AW(AW), .DW(DW), .DRW(DRW), .MDW(MDW), .STW(STW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .status_in (status_in),
        .rd_data   (rd_data),
        .drive_reg (drive_reg),
        .mode_reg  (mode_reg)
    );

    assign sdio_oe  = ~syn[1] & syn[2];
    assign sdio_out = sdio_oe & dout;
endmodule

// File: tb/test_sreg_port.sv
module test_sreg_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       sel_n = 1'b1;
    logic       rw = 1'b0;
    logic       sdio_in = 1'b0;
    logic [7:0] status_in = 8'h00;
    logic       sdio_out;
    logic       sdio_oe;
    logic [8:0] drive_reg;
    logic [11:0] mode_reg;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic  exp_q[$];
    string req_q[$];
    event  obs_ev;

    always #10 clk = ~clk;

    sreg_port i_sreg_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .sck       (sck),
        .sel_n     (sel_n),
        .rw        (rw),
        .sdio_in   (sdio_in),
        .sdio_out  (sdio_out),
        .sdio_oe   (sdio_oe),
        .status_in (status_in),
        .drive_reg (drive_reg),
        .mode_reg  (mode_reg)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input logic [11:0] act, input logic [11:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected serial bits and compares with the data line
    initial begin
        forever begin
            @(obs_ev);
            begin
                logic  e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(sdio_oe === 1'b1, {r, " oe"}, {11'd0, sdio_oe}, 12'd1);
                check(sdio_out === e, {r, " bit"}, {11'd0, sdio_out}, {11'd0, e});
            end
        end
    end

    task automatic observe(input logic b, input string req);
        exp_q.push_back(b);
        req_q.push_back(req);
        -> obs_ev;
        tick(1);
    endtask

    task automatic sbit(input logic b);
        sdio_in = b;
        tick(3);
        sck = 1'b1;
        tick(6);
        sck = 1'b0;
        tick(3);
    endtask

    task automatic wr_frame(input logic [3:0] a, input logic [11:0] d, input int nbits);
        rw = 1'b0;
        sel_n = 1'b0;
        tick(4);
        for (int i = 0; i < nbits; i++) begin
            if (i < 4) sbit(a[i]);
            else if (i < 16) sbit(d[i-4]);
            else sbit(1'b1);
        end
        sel_n = 1'b1;
        tick(6);
    endtask

    task automatic rd_frame(input logic [3:0] a, input logic [11:0] exp, input string req);
        rw = 1'b0;
        sel_n = 1'b0;
        tick(6);
        check(sdio_oe === 1'b0, "R6 oe low while rw low", {11'd0, sdio_oe}, 12'd0);
        for (int i = 0; i < 4; i++) sbit(a[i]);
        rw = 1'b1;
        tick(6);
        for (int k = 0; k < 14; k++) begin
            observe((k < 12) ? exp[k] : 1'b0, req);
            sbit(1'b0);
        end
        rw = 1'b0;
        tick(4);
        sel_n = 1'b1;
        tick(6);
        check(sdio_oe === 1'b0, "R6 oe low after deselect", {11'd0, sdio_oe}, 12'd0);
    endtask

    task automatic readback(input logic [11:0] exp);
        rw = 1'b1;
        tick(4);
        sel_n = 1'b0;
        tick(6);
        for (int k = 0; k < 12; k++) begin
            observe(exp[k], "R7 readback");
            sbit(1'b0);
        end
        sel_n = 1'b1;
        tick(4);
        rw = 1'b0;
        tick(6);
    endtask

    initial begin
        tick(5);
        // R8 reset state
        check(drive_reg === 9'd0, "R8 drive reset", {3'd0, drive_reg}, 12'd0);
        check(mode_reg === 12'd0, "R8 mode reset", mode_reg, 12'd0);
        check(sdio_oe === 1'b0, "R8 oe reset", {11'd0, sdio_oe}, 12'd0);
        rst_n = 1'b1;
        tick(5);

        // R2 clocks with select high do nothing
        for (int i = 0; i < 16; i++) sbit(1'b1);
        check(drive_reg === 9'd0, "R2 drive untouched", {3'd0, drive_reg}, 12'd0);
        check(mode_reg === 12'd0, "R2 mode untouched", mode_reg, 12'd0);

        // R3 write address 0, then R7 read-back
        wr_frame(4'd0, 12'h1A7, 16);
        check(drive_reg === 9'h1A7, "R3 drive write", {3'd0, drive_reg}, 12'h1A7);
        readback(12'h1A7);

        // R3 write address 1
        wr_frame(4'd1, 12'hC35, 16);
        check(mode_reg === 12'hC35, "R3 mode write", mode_reg, 12'hC35);
        check(drive_reg === 9'h1A7, "R3 drive kept", {3'd0, drive_reg}, 12'h1A7);

        // R4 aborted write
        wr_frame(4'd1, 12'h0FF, 10);
        check(mode_reg === 12'hC35, "R4 abort keeps mode", mode_reg, 12'hC35);
        wr_frame(4'd0, 12'h000, 15);
        check(drive_reg === 9'h1A7, "R4 abort keeps drive", {3'd0, drive_reg}, 12'h1A7);

        // R1 a 17th clock is ignored
        wr_frame(4'd1, 12'h5A3, 17);
        check(mode_reg === 12'h5A3, "R1 extra clock ignored", mode_reg, 12'h5A3);
        readback(12'h5A3);

        // R5 status reads, zero padding
        status_in = 8'hA5;
        rd_frame(4'd2, 12'h0A5, "R5 status read");
        status_in = 8'h3C;
        rd_frame(4'd2, 12'h03C, "R5 status read");

        // R9 unused and write-only addresses
        wr_frame(4'd5, 12'hFFF, 16);
        check(mode_reg === 12'h5A3, "R9 bad write mode", mode_reg, 12'h5A3);
        check(drive_reg === 9'h1A7, "R9 bad write drive", {3'd0, drive_reg}, 12'h1A7);
        rd_frame(4'd5, 12'h000, "R9 unused read");
        rd_frame(4'd0, 12'h000, "R9 write-only read");

        tick(10);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule